// File: doc/BRIEF.md
# Asynchronous Page-Mode Read Sequencer

This block drives the read side of an external asynchronous memory that supports page-mode bursts. Read requests come in on a valid/ready stream. Each request carries a 26-bit byte address and a flag that marks the last request of a burst. The block drives the memory address bus and active-low chip-select and read-strobe lines. It samples the 32-bit data bus on the final cycle of each read pulse and returns the sampled word with a one-cycle valid strobe.

The pulse length depends on whether the access lands in the page that is already open. Memory pages can be 4, 8, 16 or 32 bytes, and each page is aligned to its own size. The block stores the page number of the open page. An access that opens a page uses the longer first-access pulse. An access that stays inside the open page uses the shorter follow-on pulse. While a burst is running, the strobes stay low between accesses. The address of the next access is driven while the strobes stay asserted.

Top module: `pgrd_seq`

## Requirements
- R1: Page size encoding is 0=4, 1=8, 2=16, 3=32 bytes. The page number is the masked address shifted right by 2+encoding. An access with the page-mode enable set that finds no page open, or a page number different from the stored one, keeps the strobes low for max(1, first-access length) clock cycles.
- R2: An access with the page-mode enable set whose page number equals that of the open page keeps the strobes low for max(1, follow-on length) cycles.
- R3: Chip select and read strobe fall in the cycle after a request is accepted. They stay low through every pulse and through the waiting cycles between accesses of an open burst. Both lines always have the same level.
- R4: When the pulse of a request flagged last-of-burst ends, both strobes are high in the next cycle and the page is closed. A following request to the same page is then a first access.
- R5: With the page-mode enable clear, every access uses the first-access length and releases both strobes after its pulse.
- R6: If the page-mode enable is cleared while an open burst waits for its next request, the strobes go high on the next clock edge and the page is closed.
- R7: Device width encoding is 0=8-bit, 1=16-bit, 2=32-bit. The address bus shows the request address with bit 0 cleared for 16-bit devices and bits 1 and 0 cleared for 32-bit devices. The address stays stable during a pulse.
- R8: A programmed pulse length of zero gives a one-cycle pulse.
- R9: The data bus is sampled in the final cycle of a pulse. The word is presented on the response data output with the response valid signal high for exactly the one cycle after the pulse.
- R10: After reset the strobes are high and response valid is low. The request ready signal is high only while idle or while an open burst waits for its next request. It is low during every pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 26 | Byte address of the read |
| req_last | input | 1 | Request closes the burst |
| cfg_page_en | input | 1 | Page-mode enable |
| cfg_page_size | input | 2 | Page size encoding (R1) |
| cfg_dev_width | input | 2 | Device width encoding (R7) |
| cfg_first_len | input | 6 | First-access pulse length in cycles |
| cfg_next_len | input | 6 | Follow-on pulse length in cycles |
| mem_addr | output | 26 | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_data | input | 32 | Memory data bus |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_data | output | 32 | Read data |

## Verification
The hardest case to reach from the ports is where a follow-on access becomes a first access. This happens after a page change inside a burst that keeps the strobes low, after a burst is closed by its last flag, and after the enable is withdrawn during the wait between accesses. The bench sweeps every page size against every device width. In each sweep it sends a burst of five reads: a page opener, a hit at the far end of the page, a jump to the neighbouring page, a hit there that closes the burst, and a read of the same page after the close. A reference model of the open page in the bench predicts every pulse length and every address. Separate short sequences withdraw the enable in the wait cycle, turn page mode off, and program zero lengths.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_e;

    localparam int unsigned PAGE_SIZES     = 4;
    localparam int unsigned MIN_PAGE_LOG2  = 2;

    // number of low address bits the device ignores for a width code
    function automatic logic [1:0] ignored_lsbs(input logic [1:0] dev_width);
        case (dev_width)
            2'd0:    ignored_lsbs = 2'd0;
            2'd1:    ignored_lsbs = 2'd1;
            default: ignored_lsbs = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/pgrd_addr_map.sv
module pgrd_addr_map
    import pgrd_pkg::*;
#(
    parameter int unsigned ADDR_W = 26
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        page_size_i,
    input  logic [1:0]        dev_width_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] tag_o
);

    logic [ADDR_W-1:0] masked;
    logic [ADDR_W-1:0] cand [PAGE_SIZES];

    always_comb begin
        masked = addr_i;
        case (ignored_lsbs(dev_width_i))
            2'd1:    masked[0]   = 1'b0;
            2'd2:    masked[1:0] = 2'b00;
            default: masked      = addr_i;
        endcase
    end

    // one candidate page number per selectable page size
    for (genvar g = 0; g < PAGE_SIZES; g++) begin : g_tag
        assign cand[g] = masked >> (MIN_PAGE_LOG2 + g);
    end

    assign addr_o = masked;
    assign tag_o  = cand[page_size_i];

endmodule

// File: rtl/pgrd_pulse_timer.sv
module pgrd_pulse_timer #(
    parameter int unsigned PULSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [PULSE_W-1:0] len_i,
    output logic               busy_o,
    output logic               done_o
);

    logic [PULSE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (len_i == '0) ? PULSE_W'(1) : len_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - PULSE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == PULSE_W'(1));

    AST_LOAD_GIVES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o); // R8

endmodule

// File: rtl/pgrd_page_track.sv
module pgrd_page_track #(
    parameter int unsigned TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_o
);

    typedef struct packed {
        logic             open;
        logic [TAG_W-1:0] tag;
    } trk_t;

    trk_t d, q;

    always_comb begin
        d = q;
        if (close_i) begin
            d.open = 1'b0;
        end else if (open_i) begin
            d.open = 1'b1;
            d.tag  = tag_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hit_o = q.open && (q.tag == tag_i);

    AST_OPEN_CLOSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_i && close_i)); // R6

endmodule

// File: rtl/pgrd_seq.sv
module pgrd_seq
    import pgrd_pkg::*;
#(
    parameter int unsigned ADDR_W  = 26,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned PULSE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_last,
    input  logic               cfg_page_en,
    input  logic [1:0]         cfg_page_size,
    input  logic [1:0]         cfg_dev_width,
    input  logic [PULSE_W-1:0] cfg_first_len,
    input  logic [PULSE_W-1:0] cfg_next_len,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_cs_n,
    output logic               mem_rd_n,
    input  logic [DATA_W-1:0]  mem_data,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data
);

    typedef struct packed {
        seq_state_e        state;
        logic              strobe;
        logic              last;
        logic [ADDR_W-1:0] addr;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } seq_t;

    seq_t d, q;

    logic [ADDR_W-1:0]  map_addr, map_tag;
    logic               trk_hit, trk_open, trk_close;
    logic               tmr_load, tmr_busy, tmr_done;
    logic [PULSE_W-1:0] tmr_len;
    logic               take_ok;

    pgrd_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .addr_i      (req_addr),
        .page_size_i (cfg_page_size),
        .dev_width_i (cfg_dev_width),
        .addr_o      (map_addr),
        .tag_o       (map_tag)
    );

    pgrd_page_track #(.TAG_W(ADDR_W)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (trk_open),
        .close_i (trk_close),
        .tag_i   (map_tag),
        .hit_o   (trk_hit)
    );

    pgrd_pulse_timer #(.PULSE_W(PULSE_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .busy_o (tmr_busy),
        .done_o (tmr_done)
    );

    always_comb begin
        d           = q;
        d.rsp_valid = 1'b0;
        take_ok     = 1'b0;
        tmr_load    = 1'b0;
        tmr_len     = cfg_first_len;
        trk_open    = 1'b0;
        trk_close   = 1'b0;

        case (q.state)
            ST_IDLE: begin
                take_ok = 1'b1;
            end
            ST_GAP: begin
                if (!cfg_page_en) begin
                    d.state   = ST_IDLE;
                    d.strobe  = 1'b0;
                    trk_close = 1'b1;
                end else begin
                    take_ok = 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr_done) begin
                    d.rsp_valid = 1'b1;
                    d.rsp_data  = mem_data;
                    if (q.last || !cfg_page_en) begin
                        d.state   = ST_IDLE;
                        d.strobe  = 1'b0;
                        trk_close = 1'b1;
                    end else begin
                        d.state = ST_GAP;
                    end
                end
            end
            default: begin
                d.state  = ST_IDLE;
                d.strobe = 1'b0;
            end
        endcase

        if (take_ok && req_valid) begin
            d.state  = ST_PULSE;
            d.strobe = 1'b1;
            d.addr   = map_addr;
            d.last   = req_last;
            tmr_load = 1'b1;
            tmr_len  = (cfg_page_en && trk_hit) ? cfg_next_len : cfg_first_len;
            trk_open = cfg_page_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready = take_ok;
    assign mem_addr  = q.addr;
    assign mem_cs_n  = ~q.strobe;
    assign mem_rd_n  = ~q.strobe;
    assign rsp_valid = q.rsp_valid;
    assign rsp_data  = q.rsp_data;

    AST_ACCEPT_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !mem_cs_n && !mem_rd_n); // R3

    AST_ONE_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

    AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && q.last |-> mem_cs_n && mem_rd_n); // R4

    AST_PULSE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> !req_ready); // R10

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy && !tmr_load && $past(tmr_busy) |-> $stable(mem_addr)); // R7

endmodule

// File: tb/sim_pgrd_seq.sv
module sim_pgrd_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [25:0] req_addr = '0;
    logic        req_last = 1'b0;
    logic        cfg_page_en = 1'b1;
    logic [1:0]  cfg_page_size = 2'd0;
    logic [1:0]  cfg_dev_width = 2'd0;
    logic [5:0]  cfg_first_len = 6'd3;
    logic [5:0]  cfg_next_len = 6'd1;
    logic [25:0] mem_addr;
    logic        mem_cs_n, mem_rd_n;
    logic [31:0] mem_data;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int total = 0;
    int bad = 0;
    bit          m_open = 1'b0;
    logic [25:0] m_tag = '0;

    always #10 clk = ~clk;

    pgrd_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_last(req_last), .cfg_page_en(cfg_page_en),
        .cfg_page_size(cfg_page_size), .cfg_dev_width(cfg_dev_width),
        .cfg_first_len(cfg_first_len), .cfg_next_len(cfg_next_len),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_data(mem_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] mem_val(input logic [25:0] a);
        return {a, 6'b0} ^ 32'hA5C3_0F1E;
    endfunction

    assign mem_data = mem_val(mem_addr);

    function automatic logic [25:0] mask_addr(input logic [25:0] a, input logic [1:0] dw);
        if (dw == 2'd0) return a;
        if (dw == 2'd1) return {a[25:1], 1'b0};
        return {a[25:2], 2'b00};
    endfunction

    function automatic int eff_len(input logic [5:0] l);
        return (l == 6'd0) ? 1 : int'(l);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [25:0] a, input bit last);
        logic [25:0] ma;
        logic [25:0] tg;
        bit          first;
        bit          closing;
        int          exp_len;
        int          n;
        ma      = mask_addr(a, cfg_dev_width);
        tg      = ma >> (2 + cfg_page_size);
        first   = !cfg_page_en || !m_open || (tg != m_tag);
        exp_len = first ? eff_len(cfg_first_len) : eff_len(cfg_next_len);
        @(negedge clk);
        if (m_open)
            check(!mem_cs_n && !mem_rd_n, "R3 strobes low while waiting", {mem_cs_n, mem_rd_n}, 0);
        check(req_ready == 1'b1, "R10 ready when idle or waiting", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = a;
        req_last  = last;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 100) begin
            check(!mem_cs_n && !mem_rd_n, "R3 strobes low in pulse", {mem_cs_n, mem_rd_n}, 0);
            check(mem_addr == ma, "R7 masked address", mem_addr, ma);
            check(!req_ready, "R10 ready low in pulse", req_ready, 0);
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        if (first) check(n == exp_len, "R1 first-access pulse length", n, exp_len);
        else       check(n == exp_len, "R2 follow-on pulse length", n, exp_len);
        if ((first && cfg_first_len == 0) || (!first && cfg_next_len == 0))
            check(n == 1, "R8 zero length gives one cycle", n, 1);
        check(rsp_data == mem_val(ma), "R9 sampled data", rsp_data, mem_val(ma));
        closing = last || !cfg_page_en;
        if (closing) begin
            if (cfg_page_en)
                check(mem_cs_n && mem_rd_n, "R4 strobes released after last", {mem_cs_n, mem_rd_n}, 3);
            else
                check(mem_cs_n && mem_rd_n, "R5 strobes released without page mode", {mem_cs_n, mem_rd_n}, 3);
            m_open = 1'b0;
        end else begin
            check(!mem_cs_n && !mem_rd_n, "R3 strobes held after pulse", {mem_cs_n, mem_rd_n}, 0);
            m_open = 1'b1;
            m_tag  = tg;
        end
        @(negedge clk);
        check(!rsp_valid, "R9 valid lasts one cycle", rsp_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [25:0] base;
        int          pg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_cs_n && mem_rd_n, "R10 reset strobes high", {mem_cs_n, mem_rd_n}, 3);
        check(!rsp_valid, "R10 reset valid low", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R10 ready after reset", req_ready, 1);

        // sweep every device width against every page size
        for (int dw = 0; dw < 3; dw++) begin
            for (int ps = 0; ps < 4; ps++) begin
                cfg_dev_width = dw[1:0];
                cfg_page_size = ps[1:0];
                cfg_first_len = 6'(ps + 2 + dw);
                cfg_next_len  = 6'(dw);
                pg   = 4 << ps;
                base = 26'h0ABCD40 + 26'(64 * (dw * 4 + ps));
                do_read(base + 26'd3, 1'b0);
                do_read(base + 26'(pg - 1), 1'b0);
                do_read(base + 26'(pg + 2), 1'b0);
                do_read(base + 26'(pg), 1'b1);
                do_read(base + 26'(pg + 1), 1'b1);
            end
        end

        // page mode off
        cfg_dev_width = 2'd2;
        cfg_page_size = 2'd3;
        cfg_first_len = 6'd4;
        cfg_next_len  = 6'd1;
        cfg_page_en   = 1'b0;
        do_read(26'h0001000, 1'b0);
        do_read(26'h0001004, 1'b0);

        // enable withdrawn while waiting
        cfg_page_en = 1'b1;
        do_read(26'h0002000, 1'b0);
        cfg_page_en = 1'b0;
        @(negedge clk);
        check(mem_cs_n && mem_rd_n, "R6 strobes high after enable drop", {mem_cs_n, mem_rd_n}, 3);
        m_open = 1'b0;
        cfg_page_en = 1'b1;
        do_read(26'h0002004, 1'b1);

        // zero first-access length
        cfg_first_len = 6'd0;
        cfg_next_len  = 6'd2;
        do_read(26'h0003000, 1'b0);
        do_read(26'h0003008, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule